// File: doc/BRIEF.md
# RGB Blink and Fade Pattern Generator

This block is the timing engine behind the automatic blinking of two three-colour LED groups. Each group owns a gradation timer that divides a slow tick into a 64-position cycle whose length is picked from six power-of-two settings. Every channel has a programmable on position and off position inside that cycle, so the three colours of a group can light in any overlapping or staggered pattern. During the lit window the channel's 5-bit current code is scaled by a linear fade-in ramp after the on position and a fade-out ramp ahead of the off position.

A group can run its cycle once and then go dark, or repeat forever. A follow control makes the second group run from the first group's timer, enable and fade settings, so both groups blink in lock-step. With a group's gradation enable low, its timer sits at position 0 and its channels are driven steadily at their programmed code. The per-channel outputs, an on flag and a scaled level, feed the analogue current sinks.

Top module: `blink_fade_gen`

## Requirements
- R1: While `rst` is high, every `on_o` bit is 0 and every `lvl_o` field is 0.
- R2: With a valid period code `c` (0 to 5), each gradation position lasts 2^(BASE_LOG2+c) ticks, and positions count 0 to 63 and then wrap to 0.
- R3: Period codes 6 and 7 are invalid; with one selected and the group enabled, the position stays where it is.
- R4: A channel is lit while `(pos - on) mod 64 < (off - on) mod 64`, so the window starts at the on position, ends just before the off position and may wrap through position 63.
- R5: When a channel's on and off positions are equal, it stays unlit at every position.
- R6: An unlit channel drives level 0.
- R7: Slope code 0..7 gives a ramp length in gradation positions of 0, 1, 2, 4, 8, 16, 24 and 32 (32 is half the cycle); length 0 means no ramp.
- R8: Fade-in: at `k = (pos - on) mod 64`, the level is `floor(code*(k+1)/L)`, or `code` once `k+1 >= L`.
- R9: Fade-out: with `r = (off - pos) mod 64`, the level is `floor(code*r/L)`, or `code` once `r >= L`; a lit channel drives the smaller of the fade-in and fade-out values.
- R10: With one-shot set, once position 63 has ended the group's channels stay unlit until the gradation enable is cleared.
- R11: With `follow_i` high, group 1 (channels 3 to 5) uses group 0's position, enable, one-shot and fade settings.
- R12: With the group's enable low, its position returns to 0, and each of its channels drives `on_o` = 1 and `lvl_o` = its code.
- R13: Outputs are registered: a change of position appears on the outputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase enable, nominally 500 kHz |
| grad_en_i | input | NG | Gradation enable per group |
| period_i | input | NG x 3 | Cycle length code per group |
| one_shot_i | input | NG | Run a single cycle per group |
| fade_in_i | input | NG x 3 | Fade-in slope code per group |
| fade_out_i | input | NG x 3 | Fade-out slope code per group |
| follow_i | input | 1 | Later groups follow group 0 |
| on_pos_i | input | NCH x 6 | On position per channel |
| off_pos_i | input | NCH x 6 | Off position per channel |
| code_i | input | NCH x LVL_W | Programmed current code per channel |
| on_o | output | NCH | Channel lit flag |
| lvl_o | output | NCH x LVL_W | Scaled current level |

## Verification
The assertions take the configuration inputs to change only between clock edges and judge each output against the configuration it was registered from the cycle before. The bounding check assumes the programmed code does not change while a level is in flight. The stimulus changes inputs on falling edges only and then holds them for the whole scenario. The gradation enable is always cleared for two cycles before a new pattern starts, so every scenario begins from position 0.

// File: rtl/grad_pkg.sv
package grad_pkg;
  localparam int POS_W = 6;
  localparam int SLP_W = 3;

  // Ramp length in gradation positions for a slope code.
  function automatic logic [POS_W-1:0] slope_len(input logic [SLP_W-1:0] s);
    case (s)
      3'd0:    return 6'd0;
      3'd1:    return 6'd1;
      3'd2:    return 6'd2;
      3'd3:    return 6'd4;
      3'd4:    return 6'd8;
      3'd5:    return 6'd16;
      3'd6:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/grad_timer.sv
module grad_timer #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [2:0] at_i,
  input  logic       one_shot_i,
  output logic [5:0] pos_o,
  output logic       done_o
);
  localparam int PRE_W = BASE_LOG2 + MAX_CODE;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] lim;
  logic             valid;

  always_comb begin
    valid = (int'(at_i) <= MAX_CODE);
    span  = {{PRE_W{1'b0}}, 1'b1} << (BASE_LOG2 + int'(at_i));
    lim   = PRE_W'(span - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pre_q  <= '0;
      pos_o  <= '0;
      done_o <= 1'b0;
    end else if (tick_i && valid && !done_o) begin
      if (pre_q == lim) begin
        pre_q <= '0;
        if (pos_o == 6'd63 && one_shot_i) done_o <= 1'b1;
        else                              pos_o  <= pos_o + 6'd1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_shaper.sv
module chan_shaper
  import grad_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             done_i,
  input  logic [5:0]       pos_i,
  input  logic [5:0]       on_pos_i,
  input  logic [5:0]       off_pos_i,
  input  logic [2:0]       fin_i,
  input  logic [2:0]       fout_i,
  input  logic [LVL_W-1:0] code_i,
  output logic             on_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int PW = LVL_W + 7;

  logic [5:0]       since_on, span_w, rem;
  logic [6:0]       k1;
  logic [5:0]       lin_len, lout_len;
  logic [PW-1:0]    p_in, p_out;
  logic [LVL_W-1:0] v_in, v_out, v_min;
  logic             lit;

  always_comb begin
    since_on = pos_i - on_pos_i;
    span_w   = off_pos_i - on_pos_i;
    rem      = off_pos_i - pos_i;
    k1       = {1'b0, since_on} + 7'd1;
    lit      = since_on < span_w;
    lin_len  = slope_len(fin_i);
    lout_len = slope_len(fout_i);
    p_in     = PW'(code_i) * PW'(k1);
    p_out    = PW'(code_i) * PW'(rem);
    if (lin_len == 0 || k1 >= {1'b0, lin_len}) v_in = code_i;
    else v_in = LVL_W'(p_in / PW'(lin_len));
    if (lout_len == 0 || rem >= lout_len) v_out = code_i;
    else v_out = LVL_W'(p_out / PW'(lout_len));
    v_min = (v_in < v_out) ? v_in : v_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_o  <= 1'b0;
      lvl_o <= '0;
    end else if (!en_i) begin
      on_o  <= 1'b1;
      lvl_o <= code_i;
    end else if (done_i || !lit) begin
      on_o  <= 1'b0;
      lvl_o <= '0;
    end else begin
      on_o  <= 1'b1;
      lvl_o <= v_min;
    end
  end
endmodule

// File: rtl/blink_fade_gen.sv
module blink_fade_gen #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 5,
  parameter int NG        = 2,
  parameter int CPG       = 3,
  parameter int LVL_W     = 5,
  parameter int NCH       = NG * CPG
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic [NG-1:0]             grad_en_i,
  input  logic [NG-1:0][2:0]        period_i,
  input  logic [NG-1:0]             one_shot_i,
  input  logic [NG-1:0][2:0]        fade_in_i,
  input  logic [NG-1:0][2:0]        fade_out_i,
  input  logic                      follow_i,
  input  logic [NCH-1:0][5:0]       on_pos_i,
  input  logic [NCH-1:0][5:0]       off_pos_i,
  input  logic [NCH-1:0][LVL_W-1:0] code_i,
  output logic [NCH-1:0]            on_o,
  output logic [NCH-1:0][LVL_W-1:0] lvl_o
);
  logic [NG-1:0][5:0] t_pos;
  logic [NG-1:0]      t_done;
  logic [NG-1:0][5:0] e_pos;
  logic [NG-1:0]      e_done, e_en;
  logic [NG-1:0][2:0] e_fin, e_fout;
  logic [NCH-1:0]     ch_en;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    grad_timer #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_tmr (
      .clk        (clk),
      .rst        (rst),
      .tick_i     (tick_i),
      .en_i       (grad_en_i[g]),
      .at_i       (period_i[g]),
      .one_shot_i (one_shot_i[g]),
      .pos_o      (t_pos[g]),
      .done_o     (t_done[g])
    );
    if (g == 0) begin : g_lead
      assign e_pos[g]  = t_pos[g];
      assign e_done[g] = t_done[g];
      assign e_en[g]   = grad_en_i[g];
      assign e_fin[g]  = fade_in_i[g];
      assign e_fout[g] = fade_out_i[g];
    end else begin : g_follow
      assign e_pos[g]  = follow_i ? t_pos[0]      : t_pos[g];
      assign e_done[g] = follow_i ? t_done[0]     : t_done[g];
      assign e_en[g]   = follow_i ? grad_en_i[0]  : grad_en_i[g];
      assign e_fin[g]  = follow_i ? fade_in_i[0]  : fade_in_i[g];
      assign e_fout[g] = follow_i ? fade_out_i[0] : fade_out_i[g];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int G = i / CPG;
    assign ch_en[i] = e_en[G];
    chan_shaper #(.LVL_W(LVL_W)) u_shp (
      .clk       (clk),
      .rst       (rst),
      .en_i      (e_en[G]),
      .done_i    (e_done[G]),
      .pos_i     (e_pos[G]),
      .on_pos_i  (on_pos_i[i]),
      .off_pos_i (off_pos_i[i]),
      .fin_i     (e_fin[G]),
      .fout_i    (e_fout[G]),
      .code_i    (code_i[i]),
      .on_o      (on_o[i]),
      .lvl_o     (lvl_o[i])
    );
  end
endmodule

// File: rtl/blink_fade_chk.sv
module blink_fade_chk #(
  parameter int MAX_CODE = 5,
  parameter int NG       = 2,
  parameter int LVL_W    = 5,
  parameter int NCH      = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NG-1:0]             grad_en_i,
  input logic [NG-1:0][2:0]        period_i,
  input logic [NCH-1:0][5:0]       on_pos_i,
  input logic [NCH-1:0][5:0]       off_pos_i,
  input logic [NCH-1:0][LVL_W-1:0] code_i,
  input logic [NCH-1:0]            on_o,
  input logic [NCH-1:0][LVL_W-1:0] lvl_o,
  input logic [NG-1:0][5:0]        t_pos,
  input logic [NCH-1:0]            ch_en
);
  for (genvar g = 0; g < NG; g++) begin : g_t
    // R2: a position only steps forward by one or returns to 0
    p_pos_step_r2: assert property (@(posedge clk) disable iff (rst)
      (t_pos[g] != $past(t_pos[g])) |-> (t_pos[g] == $past(t_pos[g]) + 6'd1 || t_pos[g] == 6'd0));
    // R3: an invalid period code holds the position
    p_freeze_invalid_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(grad_en_i[g]) && int'($past(period_i[g])) > MAX_CODE)
        |-> t_pos[g] == $past(t_pos[g]));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R6: unlit channels carry no level
    p_off_level_zero_r6: assert property (@(posedge clk) disable iff (rst)
      !on_o[i] |-> lvl_o[i] == '0);
    // R5: equal positions keep the channel dark
    p_equal_dark_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ch_en[i]) && $past(on_pos_i[i] == off_pos_i[i])) |-> !on_o[i]);
    // R12: a disabled group drives the static code
    p_static_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ch_en[i])) |-> (on_o[i] && lvl_o[i] == $past(code_i[i])));
    // R8: a ramped level never exceeds the programmed code
    p_level_bound_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ch_en[i])) |-> lvl_o[i] <= $past(code_i[i]));
  end
endmodule

bind blink_fade_gen blink_fade_chk #(
  .MAX_CODE(MAX_CODE), .NG(NG), .LVL_W(LVL_W), .NCH(NCH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .grad_en_i (grad_en_i),
  .period_i  (period_i),
  .on_pos_i  (on_pos_i),
  .off_pos_i (off_pos_i),
  .code_i    (code_i),
  .on_o      (on_o),
  .lvl_o     (lvl_o),
  .t_pos     (t_pos),
  .ch_en     (ch_en)
);

// File: tb/sim_blink_fade_gen.sv
module sim_blink_fade_gen;
  localparam int BL = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick = 1'b1;
  logic [1:0]      grad_en;
  logic [1:0][2:0] period, fin, fout;
  logic [1:0]      one_shot;
  logic            follow;
  logic [5:0][5:0] on_pos, off_pos;
  logic [5:0][4:0] code;
  logic [5:0]      on_o;
  logic [5:0][4:0] lvl_o;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;

  always #4 clk = ~clk;

  blink_fade_gen #(.BASE_LOG2(BL)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .grad_en_i(grad_en), .period_i(period),
    .one_shot_i(one_shot), .fade_in_i(fin), .fade_out_i(fout), .follow_i(follow),
    .on_pos_i(on_pos), .off_pos_i(off_pos), .code_i(code), .on_o(on_o), .lvl_o(lvl_o)
  );

  task automatic chk(input string tag, input int ch, input logic e_on, input int e_lvl);
    n_chk++;
    if (on_o[ch] !== e_on || int'(lvl_o[ch]) != e_lvl) begin
      n_bad++;
      $display("FAIL %s ch%0d: on=%b lvl=%0d expected on=%b lvl=%0d",
               tag, ch, on_o[ch], lvl_o[ch], e_on, e_lvl);
    end
  endtask

  task automatic clear_cfg();
    @(negedge clk);
    grad_en = '0; period = '0; fin = '0; fout = '0; one_shot = '0; follow = 1'b0;
    on_pos = '0; off_pos = '0; code = '0;
  endtask

  // Restart both timers from position 0 with the given enables.
  task automatic arm(input logic [1:0] m);
    @(negedge clk); grad_en = '0;
    @(negedge clk);
    @(negedge clk); grad_en = m;
    edges = 0;
  endtask

  // Move to the middle of the output window of position p (G clocks per position).
  task automatic goto(input int p, input int g);
    int need;
    need = g * p + g / 2 + 1;
    repeat (need - edges) @(posedge clk);
    edges = need;
    #2;
  endtask

  task automatic t_reset();
    #2;
    chk("R1", 0, 1'b0, 0);
    chk("R1", 5, 1'b0, 0);
  endtask

  task automatic t_static();
    clear_cfg();
    code[0] = 5'd13; code[4] = 5'd31;
    repeat (2) @(posedge clk); #2;
    chk("R12", 0, 1'b1, 13);
    chk("R12", 4, 1'b1, 31);
  endtask

  task automatic t_window();
    clear_cfg();
    off_pos[0] = 6'd5;  code[0] = 5'd10;
    on_pos[1] = 6'd60; off_pos[1] = 6'd4; code[1] = 5'd7;
    arm(2'b01);
    goto(0, 4);  chk("R13", 0, 1'b1, 10);
    goto(4, 4);  chk("R4", 0, 1'b1, 10);
    goto(5, 4);  chk("R6", 0, 1'b0, 0);
    goto(40, 4); chk("R4", 0, 1'b0, 0);
    goto(62, 4); chk("R4", 1, 1'b1, 7);
    goto(66, 4); chk("R4", 1, 1'b1, 7);
    goto(70, 4); chk("R4", 1, 1'b0, 0);
  endtask

  task automatic t_equal();
    clear_cfg();
    on_pos[2] = 6'd9; off_pos[2] = 6'd9; code[2] = 5'd20;
    arm(2'b01);
    goto(9, 4);  chk("R5", 2, 1'b0, 0);
    goto(30, 4); chk("R5", 2, 1'b0, 0);
  endtask

  task automatic t_period();
    clear_cfg();
    period[0] = 3'd1; off_pos[0] = 6'd3; code[0] = 5'd4;
    arm(2'b01);
    goto(2, 8); chk("R2", 0, 1'b1, 4);
    goto(3, 8); chk("R2", 0, 1'b0, 0);
  endtask

  task automatic t_invalid();
    clear_cfg();
    period[0] = 3'd6; off_pos[0] = 6'd5; code[0] = 5'd9;
    arm(2'b01);
    goto(10, 4); chk("R3", 0, 1'b1, 9);
    goto(70, 4); chk("R3", 0, 1'b1, 9);
  endtask

  task automatic t_fade_in();
    clear_cfg();
    fin[0] = 3'd4; off_pos[0] = 6'd20; code[0] = 5'd16;
    fin[1] = 3'd6; off_pos[3] = 6'd40; code[3] = 5'd24;
    arm(2'b11);
    goto(0, 4);  chk("R8", 0, 1'b1, 2);
    goto(3, 4);  chk("R8", 0, 1'b1, 8);
    goto(5, 4);  chk("R7", 3, 1'b1, 6);
    goto(7, 4);  chk("R8", 0, 1'b1, 16);
    goto(10, 4); chk("R8", 0, 1'b1, 16);
    goto(23, 4); chk("R7", 3, 1'b1, 24);
  endtask

  task automatic t_fade_out();
    clear_cfg();
    fout[0] = 3'd3; off_pos[0] = 6'd20; code[0] = 5'd16;
    fin[1] = 3'd5; fout[1] = 3'd3; off_pos[3] = 6'd6; code[3] = 5'd16;
    arm(2'b11);
    goto(2, 4);  chk("R9", 3, 1'b1, 3);
    goto(5, 4);  chk("R9", 3, 1'b1, 4);
    goto(16, 4); chk("R9", 0, 1'b1, 16);
    goto(18, 4); chk("R9", 0, 1'b1, 8);
    goto(19, 4); chk("R9", 0, 1'b1, 4);
    goto(20, 4); chk("R9", 0, 1'b0, 0);
  endtask

  task automatic t_one_shot();
    clear_cfg();
    one_shot[0] = 1'b1;
    off_pos[0] = 6'd40; code[0] = 5'd5;
    off_pos[3] = 6'd40; code[3] = 5'd5;
    arm(2'b11);
    goto(10, 4); chk("R10", 0, 1'b1, 5);
    goto(69, 4); chk("R10", 0, 1'b0, 0);
    chk("R10", 3, 1'b1, 5);
  endtask

  task automatic t_follow();
    clear_cfg();
    follow = 1'b1;
    fin[0] = 3'd4; period[1] = 3'd6;
    off_pos[3] = 6'd5; code[3] = 5'd9;
    arm(2'b11);
    goto(3, 4);  chk("R11", 3, 1'b1, 4);
    goto(10, 4); chk("R11", 3, 1'b0, 0);
  endtask

  initial begin
    grad_en = '0; period = '0; fin = '0; fout = '0; one_shot = '0; follow = 1'b0;
    on_pos = '0; off_pos = '0; code = '0;
    repeat (4) @(posedge clk);
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_static();
    t_window();
    t_equal();
    t_period();
    t_invalid();
    t_fade_in();
    t_fade_out();
    t_one_shot();
    t_follow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule